// File: doc/BRIEF.md
# Frequency Synthesizer Parameter Search Engine

This block picks the settings for a fractional-free clock synthesizer: a reference divider M, a feedback multiplier N, a power-of-two post-divider 2^E and an integer output divider DIV. Given a target frequency in Hz and up to three reference candidates, each with its own enable flag, it walks every legal combination and keeps the one whose delivered frequency lands closest to the target. A mode input decides whether a fixed divide-by-7 (bit clock to pixel clock) sits between the post-divider and DIV.

Software or a sequencer loads the target, the reference frequencies and the mode, and pulses `start`. The engine latches these, raises `busy`, and works through the search with one shared bit-serial divider, so one candidate takes about a hundred cycles. When the search ends it pulses `done` for one cycle and holds the best settings, the winning reference index and the absolute error until the next start. If no reference is usable it flags that instead.

Top module: `clk_param_search`

## Requirements
- R1: After reset busy, done and no_sol are 0, best_m, best_n, best_e, best_div and best_src are 0 and best_err is all ones.
- R2: Reference k (k = 0, 1, 2 on src_hz[k], src_valid[k]) is searched only if its valid bit is 1 and 12,000,000 <= frequency <= 192,000,000 Hz, both bounds inclusive; other references contribute no candidate.
- R3: For a reference Fin, M takes every integer from max(1, ceil(Fin/24e6)) to min(8, floor(Fin/12e6)), ascending, and the comparison frequency is Fp = floor(Fin/M).
- R4: N takes every integer from max(60, ceil(900e6/Fp)) up to but not including min(120, floor(1800e6/Fp)), ascending.
- R5: E takes 0, 1, 2 ascending, except that E = 0 is skipped when the oscillator frequency Fv = Fp*N exceeds 1,039,500,000 Hz.
- R6: The post-divider output is Fo = floor(Fv / 2^E), further integer-divided by 7 when dot_only is 0 and left as is when dot_only is 1.
- R7: DIV = max(1, floor((Fo + floor(T/2)) / T)) for target T >= 1, the delivered frequency is floor(Fo/DIV) and the candidate error is its absolute difference from T.
- R8: References are tried in index order 0, 1, 2, and within one reference in the M, N, E order above; a candidate replaces the kept result only if its error is strictly smaller, so on a tie the earliest candidate wins.
- R9: A candidate with zero error ends the whole search at once; later references are not visited, so the time from start to done does not depend on them.
- R10: When no candidate exists, done rises with no_sol = 1, best_err all ones and every other result output 0; otherwise no_sol = 0.
- R11: start is accepted only while busy is 0; busy is 1 from the cycle after an accepted start until done; done is a single-cycle pulse with busy 0; start during busy is ignored; results hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search (sampled while idle) |
| target_hz | input | 32 | Wanted output frequency in Hz, at least 1 |
| src_hz | input | 3x32 | Reference frequencies in Hz, index 0 to 2 |
| src_valid | input | 3 | Per-reference enable |
| dot_only | input | 1 | 1 removes the fixed divide-by-7 |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| no_sol | output | 1 | No legal candidate was found |
| best_m | output | 4 | Chosen reference divider M |
| best_n | output | 7 | Chosen multiplier N |
| best_e | output | 2 | Chosen post-divider exponent E |
| best_div | output | 32 | Chosen output divider DIV |
| best_src | output | 2 | Index of the chosen reference |
| best_err | output | 32 | Absolute error of the chosen candidate in Hz |

## Verification
The end of one search and the start of the next can meet in one cycle: the bench drives `start` with a new configuration during the very cycle in which `done` is high, and the scoreboard must then receive both result sets, each matching the bench's own search model. The opposite collision, a `start` arriving mid-search, is judged by requiring exactly one `done` carrying the first configuration's results and no later pulse. The early-exit rule is judged by timing: an exact match on reference 0 must complete in the same number of cycles whether or not references 1 and 2 are enabled.

// File: rtl/clksrch_pkg.sv
package clksrch_pkg;

    // Sequencer states of the search engine
    typedef enum logic [3:0] {
        S_IDLE,
        S_SRC,   // pick next usable reference
        S_MLO,   // lower bound of M
        S_MHI,   // upper bound of M
        S_MCHK,  // M loop test
        S_PFD,   // comparison frequency
        S_NLO,   // lower bound of N
        S_NHI,   // upper bound of N
        S_NCHK,  // N loop test, oscillator product
        S_ESEL,  // E loop test, post-divider shift
        S_SEV,   // fixed divide-by-7
        S_RND,   // nearest-integer output divider
        S_ACT,   // delivered frequency
        S_CMP,   // compare with kept result
        S_FIN
    } srch_st_e;

endpackage

// File: rtl/clksrch_divider.sv
module clksrch_divider #(
    parameter int DW = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          rdy,
    output logic [DW-1:0] quo
);
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        logic          run;
        logic          rdy;
        logic [CW-1:0] cnt;
        logic [DW-1:0] rem;
        logic [DW-1:0] q;
        logic [DW-1:0] den;
        logic [DW-1:0] num;
    } div_regs_t;

    div_regs_t r_q, r_d;
    logic [DW:0] shifted;

    always_comb begin
        r_d     = r_q;
        r_d.rdy = 1'b0;
        shifted = {r_q.rem, r_q.q[DW-1]};
        if (go) begin
            r_d.run = 1'b1;
            r_d.cnt = CW'(DW);
            r_d.rem = '0;
            r_d.q   = num;
            r_d.den = den;
            r_d.num = num;
        end else if (r_q.run) begin
            if (shifted >= {1'b0, r_q.den}) begin
                r_d.rem = DW'(shifted - {1'b0, r_q.den});
                r_d.q   = {r_q.q[DW-2:0], 1'b1};
            end else begin
                r_d.rem = shifted[DW-1:0];
                r_d.q   = {r_q.q[DW-2:0], 1'b0};
            end
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CW'(1)) begin
                r_d.run = 1'b0;
                r_d.rdy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdy = r_q.rdy;
    assign quo = r_q.q;

    // R7: every quotient handed out is the floor of num/den
    a_r7_quot_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && r_q.den != '0) |->
            ((2*DW)'(quo) * (2*DW)'(r_q.den) <= (2*DW)'(r_q.num)) &&
            (((2*DW)'(quo) + 1) * (2*DW)'(r_q.den) > (2*DW)'(r_q.num)));

endmodule

// File: rtl/clksrch_srcwin.sv
module clksrch_srcwin #(
    parameter int          NSRC = 3,
    parameter int          FW   = 32,
    parameter int unsigned LO   = 12_000_000,
    parameter int unsigned HI   = 192_000_000
) (
    input  logic [NSRC-1:0][FW-1:0] hz,
    input  logic [NSRC-1:0]         vld,
    output logic [NSRC-1:0]         ok
);
    for (genvar g = 0; g < NSRC; g++) begin : g_win
        assign ok[g] = vld[g] && (hz[g] >= FW'(LO)) && (hz[g] <= FW'(HI));
    end
endmodule

// File: rtl/clksrch_abserr.sv
module clksrch_abserr #(
    parameter int DW = 33,
    parameter int FW = 32
) (
    input  logic [DW-1:0] ach,
    input  logic [FW-1:0] tgt,
    output logic [DW-1:0] err
);
    logic [DW-1:0] t_ext;

    always_comb begin
        t_ext = DW'(tgt);
        if (ach >= t_ext) err = ach - t_ext;
        else              err = t_ext - ach;
    end
endmodule

// File: rtl/clk_param_search.sv
module clk_param_search
    import clksrch_pkg::*;
#(
    parameter int          FW         = 32,
    parameter int          NSRC       = 3,
    parameter int          M_MAX      = 8,
    parameter int          N_LO       = 60,
    parameter int          N_HI       = 120,
    parameter int          E_CNT      = 3,
    parameter int unsigned POST_DIV   = 7,
    parameter int unsigned FIN_MIN    = 12_000_000,
    parameter int unsigned FIN_MAX    = 192_000_000,
    parameter int unsigned PFD_MIN    = 12_000_000,
    parameter int unsigned PFD_MAX    = 24_000_000,
    parameter int unsigned VCO_MIN    = 900_000_000,
    parameter int unsigned VCO_MAX    = 1_800_000_000,
    parameter int unsigned E0_VCO_MAX = 1_039_500_000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [FW-1:0]           target_hz,
    input  logic [NSRC-1:0][FW-1:0] src_hz,
    input  logic [NSRC-1:0]         src_valid,
    input  logic                    dot_only,
    output logic                    busy,
    output logic                    done,
    output logic                    no_sol,
    output logic [$clog2(M_MAX+2)-1:0] best_m,
    output logic [$clog2(N_HI+2)-1:0]  best_n,
    output logic [$clog2(E_CNT+1)-1:0] best_e,
    output logic [FW-1:0]           best_div,
    output logic [$clog2(NSRC+1)-1:0]  best_src,
    output logic [FW-1:0]           best_err
);
    localparam int DW = FW + 1;
    localparam int SW = $clog2(NSRC + 1);
    localparam int MW = $clog2(M_MAX + 2);
    localparam int NW = $clog2(N_HI + 2);
    localparam int EW = $clog2(E_CNT + 1);

    typedef struct packed {
        srch_st_e               st;
        logic                   wt;
        logic [SW-1:0]          src;
        logic [NSRC-1:0][FW-1:0] hz;
        logic [NSRC-1:0]        vld;
        logic [FW-1:0]          tgt;
        logic                   dot;
        logic [FW-1:0]          fin;
        logic [MW-1:0]          m;
        logic [MW-1:0]          mhi;
        logic [FW-1:0]          fpfd;
        logic [NW-1:0]          n;
        logic [NW-1:0]          nhi;
        logic [DW-1:0]          fvco;
        logic [EW-1:0]          e;
        logic [DW-1:0]          fout;
        logic [FW-1:0]          dv;
        logic [DW-1:0]          ach;
        logic                   found;
        logic                   nos;
        logic                   done;
        logic [MW-1:0]          bm;
        logic [NW-1:0]          bn;
        logic [EW-1:0]          be;
        logic [FW-1:0]          bdiv;
        logic [SW-1:0]          bsrc;
        logic [FW-1:0]          berr;
    } srch_regs_t;

    srch_regs_t r_q, r_d;

    logic [NSRC-1:0] src_ok;
    logic [FW-1:0]   sel_hz;
    logic            sel_ok;
    logic            bsrc_ok;
    logic            div_go, div_rdy, div_take, is_div_st;
    logic [DW-1:0]   div_num, div_den, quo;
    logic [DW-1:0]   cand_err;
    logic            better;

    clksrch_srcwin #(
        .NSRC(NSRC), .FW(FW), .LO(FIN_MIN), .HI(FIN_MAX)
    ) u_srcwin (
        .hz (r_q.hz),
        .vld(r_q.vld),
        .ok (src_ok)
    );

    clksrch_divider #(.DW(DW)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (div_num),
        .den  (div_den),
        .rdy  (div_rdy),
        .quo  (quo)
    );

    clksrch_abserr #(.DW(DW), .FW(FW)) u_err (
        .ach(r_q.ach),
        .tgt(r_q.tgt),
        .err(cand_err)
    );

    // Reference selection by index, also for the kept winner
    always_comb begin
        sel_hz  = '0;
        sel_ok  = 1'b0;
        bsrc_ok = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (r_q.src == SW'(i)) begin
                sel_hz = r_q.hz[i];
                sel_ok = src_ok[i];
            end
            if (r_q.bsrc == SW'(i)) bsrc_ok = src_ok[i];
        end
    end

    // Operands for the shared divider, chosen by the current step
    always_comb begin
        div_num = DW'(r_q.fin);
        div_den = DW'(PFD_MIN);
        case (r_q.st)
            S_MLO: begin
                div_num = DW'(r_q.fin) + DW'(PFD_MAX - 1);
                div_den = DW'(PFD_MAX);
            end
            S_PFD: begin
                div_num = DW'(r_q.fin);
                div_den = DW'(r_q.m);
            end
            S_NLO: begin
                div_num = DW'(VCO_MIN) + DW'(r_q.fpfd) - DW'(1);
                div_den = DW'(r_q.fpfd);
            end
            S_NHI: begin
                div_num = DW'(VCO_MAX);
                div_den = DW'(r_q.fpfd);
            end
            S_SEV: begin
                div_num = r_q.fout;
                div_den = DW'(POST_DIV);
            end
            S_RND: begin
                div_num = r_q.fout + DW'(r_q.tgt >> 1);
                div_den = DW'(r_q.tgt);
            end
            S_ACT: begin
                div_num = r_q.fout;
                div_den = DW'(r_q.dv);
            end
            default: ;
        endcase
    end

    assign is_div_st = r_q.st inside {S_MLO, S_MHI, S_PFD, S_NLO, S_NHI,
                                      S_SEV, S_RND, S_ACT};
    assign div_take  = r_q.wt && div_rdy;
    assign better    = cand_err < DW'(r_q.berr);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        div_go   = 1'b0;

        if (is_div_st && !r_q.wt) begin
            div_go = 1'b1;
            r_d.wt = 1'b1;
        end else if (div_take) begin
            r_d.wt = 1'b0;
        end

        case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.st    = S_SRC;
                    r_d.src   = '0;
                    r_d.hz    = src_hz;
                    r_d.vld   = src_valid;
                    r_d.tgt   = target_hz;
                    r_d.dot   = dot_only;
                    r_d.found = 1'b0;
                    r_d.nos   = 1'b0;
                    r_d.bm    = '0;
                    r_d.bn    = '0;
                    r_d.be    = '0;
                    r_d.bdiv  = '0;
                    r_d.bsrc  = '0;
                    r_d.berr  = '1;
                end
            end
            S_SRC: begin
                if (r_q.src == SW'(NSRC)) begin
                    r_d.st = S_FIN;
                end else if (sel_ok) begin
                    r_d.fin = sel_hz;
                    r_d.st  = S_MLO;
                end else begin
                    r_d.src = r_q.src + 1'b1;
                end
            end
            S_MLO: if (div_take) begin
                if (quo == '0)                r_d.m = MW'(1);
                else if (quo > DW'(M_MAX))    r_d.m = MW'(M_MAX + 1);
                else                          r_d.m = MW'(quo);
                r_d.st = S_MHI;
            end
            S_MHI: if (div_take) begin
                r_d.mhi = (quo > DW'(M_MAX)) ? MW'(M_MAX) : MW'(quo);
                r_d.st  = S_MCHK;
            end
            S_MCHK: begin
                if (r_q.m > r_q.mhi) begin
                    r_d.src = r_q.src + 1'b1;
                    r_d.st  = S_SRC;
                end else begin
                    r_d.st = S_PFD;
                end
            end
            S_PFD: if (div_take) begin
                r_d.fpfd = quo[FW-1:0];
                r_d.st   = S_NLO;
            end
            S_NLO: if (div_take) begin
                if (quo < DW'(N_LO))      r_d.n = NW'(N_LO);
                else if (quo > DW'(N_HI)) r_d.n = NW'(N_HI);
                else                      r_d.n = NW'(quo);
                r_d.st = S_NHI;
            end
            S_NHI: if (div_take) begin
                r_d.nhi = (quo > DW'(N_HI)) ? NW'(N_HI) : NW'(quo);
                r_d.st  = S_NCHK;
            end
            S_NCHK: begin
                if (r_q.n >= r_q.nhi) begin
                    r_d.m  = r_q.m + 1'b1;
                    r_d.st = S_MCHK;
                end else begin
                    r_d.fvco = DW'(r_q.fpfd) * DW'(r_q.n);
                    r_d.e    = ((DW'(r_q.fpfd) * DW'(r_q.n)) > DW'(E0_VCO_MAX))
                               ? EW'(1) : EW'(0);
                    r_d.st   = S_ESEL;
                end
            end
            S_ESEL: begin
                if (r_q.e >= EW'(E_CNT)) begin
                    r_d.n  = r_q.n + 1'b1;
                    r_d.st = S_NCHK;
                end else begin
                    r_d.fout = r_q.fvco >> r_q.e;
                    r_d.st   = r_q.dot ? S_RND : S_SEV;
                end
            end
            S_SEV: if (div_take) begin
                r_d.fout = quo;
                r_d.st   = S_RND;
            end
            S_RND: if (div_take) begin
                r_d.dv = (quo == '0) ? FW'(1) : quo[FW-1:0];
                r_d.st = S_ACT;
            end
            S_ACT: if (div_take) begin
                r_d.ach = quo;
                r_d.st  = S_CMP;
            end
            S_CMP: begin
                if (better) begin
                    r_d.found = 1'b1;
                    r_d.bm    = r_q.m;
                    r_d.bn    = r_q.n;
                    r_d.be    = r_q.e;
                    r_d.bdiv  = r_q.dv;
                    r_d.bsrc  = r_q.src;
                    r_d.berr  = cand_err[FW-1:0];
                end
                if (better && cand_err == '0) begin
                    r_d.st = S_FIN;
                end else begin
                    r_d.e  = r_q.e + 1'b1;
                    r_d.st = S_ESEL;
                end
            end
            S_FIN: begin
                r_d.done = 1'b1;
                r_d.nos  = !r_q.found;
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= S_IDLE;
            r_q.berr <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != S_IDLE);
    assign done     = r_q.done;
    assign no_sol   = r_q.nos;
    assign best_m   = r_q.bm;
    assign best_n   = r_q.bn;
    assign best_e   = r_q.be;
    assign best_div = r_q.bdiv;
    assign best_src = r_q.bsrc;
    assign best_err = r_q.berr;

    // R11: done lasts exactly one cycle and only while idle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: an empty search reports the cleared result set
    a_r10_empty_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_sol) |-> (best_err == '1 && best_m == '0 &&
                              best_div == '0 && best_n == '0));

    // R3: winning M lies in the legal range
    a_r3_m_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_sol) |-> (best_m >= MW'(1) && best_m <= MW'(M_MAX)));

    // R4: winning N lies in the legal range
    a_r4_n_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_sol) |-> (best_n >= NW'(N_LO) && best_n < NW'(N_HI)));

    // R5: winning E is a legal exponent
    a_r5_e_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_sol) |-> (best_e < EW'(E_CNT)));

    // R7: the output divider is never zero
    a_r7_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_sol) |-> (best_div != '0));

    // R2: the winner comes from a reference that passed the window
    a_r2_src_usable: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_sol) |-> bsrc_ok);

    // R8: within a search the kept error never grows
    a_r8_err_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (best_err <= $past(best_err)));

endmodule

// File: tb/clk_param_search_tb.sv
module clk_param_search_tb;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       target_hz = '0;
    logic [2:0][31:0]  src_hz = '0;
    logic [2:0]        src_valid = '0;
    logic              dot_only = 1'b0;
    logic              busy, done, no_sol;
    logic [3:0]        best_m;
    logic [6:0]        best_n;
    logic [1:0]        best_e;
    logic [31:0]       best_div;
    logic [1:0]        best_src;
    logic [31:0]       best_err;

    clk_param_search u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .target_hz(target_hz),
        .src_hz(src_hz), .src_valid(src_valid), .dot_only(dot_only),
        .busy(busy), .done(done), .no_sol(no_sol), .best_m(best_m),
        .best_n(best_n), .best_e(best_e), .best_div(best_div),
        .best_src(best_src), .best_err(best_err)
    );

    always #5 clk = ~clk;

    typedef struct {
        string  tag;
        bit     nosol;
        longint m, n, e, dv, src, err;
    } exp_t;

    exp_t   sb[$];
    int     n_chk = 0, n_bad = 0, n_done = 0;
    longint cyc = 0, t_start = 0, last_lat = 0;

    always @(posedge clk) cyc++;

    task automatic chk(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Search model written from R2..R9
    function automatic exp_t model(string tag, longint tgt, longint f0, longint f1,
                                   longint f2, bit [2:0] v, bit dot);
        exp_t   r;
        longint fa[3];
        longint best, mlo, mhi, pf, nlo, nhi, vco, fo, dv, ach, df;
        bit     stop, found;
        fa[0] = f0; fa[1] = f1; fa[2] = f2;
        best = 64'd4294967295;
        stop = 0; found = 0;
        r.tag = tag; r.m = 0; r.n = 0; r.e = 0; r.dv = 0; r.src = 0; r.err = best;
        for (int s = 0; s < 3 && !stop; s++) begin
            if (!v[s] || fa[s] < 12000000 || fa[s] > 192000000) continue;
            mlo = (fa[s] + 23999999) / 24000000;
            if (mlo < 1) mlo = 1;
            mhi = fa[s] / 12000000;
            if (mhi > 8) mhi = 8;
            for (longint m = mlo; m <= mhi && !stop; m++) begin
                pf  = fa[s] / m;
                nlo = (900000000 + pf - 1) / pf;
                if (nlo < 60) nlo = 60;
                nhi = 1800000000 / pf;
                if (nhi > 120) nhi = 120;
                for (longint n = nlo; n < nhi && !stop; n++) begin
                    vco = pf * n;
                    for (longint e = (vco > 1039500000) ? 1 : 0; e < 3 && !stop; e++) begin
                        fo = vco >> e;
                        if (!dot) fo = fo / 7;
                        dv = (fo + tgt / 2) / tgt;
                        if (dv < 1) dv = 1;
                        ach = fo / dv;
                        df  = (ach > tgt) ? ach - tgt : tgt - ach;
                        if (df < best) begin
                            best = df; found = 1;
                            r.m = m; r.n = n; r.e = e; r.dv = dv; r.src = s; r.err = df;
                            if (df == 0) stop = 1;
                        end
                    end
                end
            end
        end
        r.nosol = !found;
        return r;
    endfunction

    // Monitor: pops the scoreboard on every done pulse
    always @(negedge clk) begin
        exp_t x;
        if (rst_n && done) begin
            n_done++;
            last_lat = cyc - t_start;
            if (sb.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R11 unexpected done: actual 1 expected 0");
            end else begin
                x = sb.pop_front();
                chk(x.tag, "no_sol",   no_sol,   x.nosol);
                chk(x.tag, "best_m",   best_m,   x.m);
                chk(x.tag, "best_n",   best_n,   x.n);
                chk(x.tag, "best_e",   best_e,   x.e);
                chk(x.tag, "best_div", best_div, x.dv);
                chk(x.tag, "best_src", best_src, x.src);
                chk(x.tag, "best_err", best_err, x.err);
            end
        end
    end

    task automatic drive(longint tgt, longint f0, longint f1, longint f2,
                         bit [2:0] v, bit dot);
        target_hz = tgt[31:0];
        src_hz[0] = f0[31:0];
        src_hz[1] = f1[31:0];
        src_hz[2] = f2[31:0];
        src_valid = v;
        dot_only  = dot;
    endtask

    task automatic kick(longint tgt, longint f0, longint f1, longint f2,
                        bit [2:0] v, bit dot);
        @(negedge clk);
        drive(tgt, f0, f1, f2, v, dot);
        start   = 1'b1;
        t_start = cyc;
        @(negedge clk);
        start = 1'b0;
        chk("R11", "busy after start", busy, 1);
    endtask

    task automatic wait_done();
        int k = n_done;
        while (n_done == k) @(negedge clk);
    endtask

    task automatic run(string tag, longint tgt, longint f0, longint f1, longint f2,
                       bit [2:0] v, bit dot);
        sb.push_back(model(tag, tgt, f0, f1, f2, v, dot));
        kick(tgt, f0, f1, f2, v, dot);
        wait_done();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected done");
        finish_up();
    end

    initial begin
        longint lat1, held_err, held_div;
        int     k;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "busy",     busy, 0);
        chk("R1", "done",     done, 0);
        chk("R1", "no_sol",   no_sol, 0);
        chk("R1", "best_err", best_err, 64'd4294967295);
        chk("R1", "best_m",   best_m, 0);
        chk("R1", "best_div", best_div, 0);

        // R6: divide-by-7 path, single reference
        run("R6", 50_000_000, 24_000_000, 0, 0, 3'b001, 1'b0);
        // R6: dot-only path; reference 0 carries a value but is not enabled (R2)
        run("R6", 148_500_000, 30_000_000, 12_000_000, 0, 3'b010, 1'b1);
        // R2, R10: references just outside the window, third disabled
        run("R10", 100_000_000, 11_999_999, 192_000_001, 50_000_000, 3'b011, 1'b0);
        chk("R10", "no_sol flag", no_sol, 1);

        // R9: exact match on reference 0 (M=1, N=75 per R3, R4), then with more references
        run("R9", 900_000_000, 12_000_000, 0, 0, 3'b001, 1'b1);
        lat1 = last_lat;
        chk("R4", "exact n", best_n, 75);
        run("R9", 900_000_000, 12_000_000, 192_000_000, 27_000_000, 3'b111, 1'b1);
        chk("R9", "latency with later references", last_lat, lat1);

        // R3, R2: upper boundary reference 192 MHz, M must be 8
        run("R3", 33_000_000, 0, 0, 192_000_000, 3'b100, 1'b0);
        chk("R3", "m at top edge", best_m, 8);
        // R5: every oscillator value here exceeds the E=0 limit
        chk("R5", "e nonzero", (best_e >= 1), 1);

        // R8: identical references, earliest wins
        run("R8", 7_777_777, 20_000_000, 20_000_000, 20_000_000, 3'b111, 1'b0);
        chk("R8", "earliest source", best_src, 0);

        // R7: small target forces a large output divider
        run("R7", 2_500_000, 20_000_000, 0, 0, 3'b001, 1'b0);

        // R11: start during busy is ignored, results hold afterwards
        sb.push_back(model("R11", 31_000_000, 0, 20_000_000, 0, 3'b010, 1'b0));
        kick(31_000_000, 0, 20_000_000, 0, 3'b010, 1'b0);
        repeat (200) @(negedge clk);
        drive(66_000_000, 24_000_000, 0, 0, 3'b001, 1'b1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        held_err = best_err;
        held_div = best_div;
        k = n_done;
        repeat (40) @(negedge clk);
        chk("R11", "no second done", n_done, k);
        chk("R11", "err held", best_err, held_err);
        chk("R11", "div held", best_div, held_div);

        // R11: new start in the same cycle as done
        sb.push_back(model("R11", 40_000_000, 20_000_000, 0, 0, 3'b001, 1'b1));
        sb.push_back(model("R11", 66_000_000, 0, 20_000_000, 0, 3'b010, 1'b0));
        kick(40_000_000, 20_000_000, 0, 0, 3'b001, 1'b1);
        while (!done) @(negedge clk);
        drive(66_000_000, 0, 20_000_000, 0, 3'b010, 1'b0);
        start   = 1'b1;
        t_start = cyc;
        @(negedge clk);
        start = 1'b0;
        chk("R11", "busy after back-to-back start", busy, 1);
        wait_done();
        chk("R11", "scoreboard drained", sb.size(), 0);

        repeat (5) @(negedge clk);
        finish_up();
    end

endmodule